// File: doc/BRIEF.md
# UART Prioritized Interrupt Identifier

This block merges the interrupt sources of a UART channel into one active-high level interrupt and an 8-bit identification byte that software reads to learn which cause to service. The sources are a receiver line-status error, a received-data-available condition, a character timeout, a transmit-holding-register-empty event and a modem-status request. Each source has its own bit in a 4-bit enable value. The block also derives the data-available condition from the receive FIFO fill count and the selected trigger level.

The holding-register-empty source is an event, not a level. The block latches it and clears it when software writes the transmit register. It also clears it when software reads the identification byte while that source is the one reported. All other sources are levels that the surrounding logic holds until they are serviced.

The core is a state machine whose state is the source currently reported. It has six states: `SRC_NONE`, `SRC_LINE`, `SRC_DATA`, `SRC_TOUT`, `SRC_TXE` and `SRC_MODEM`. On every clock edge it moves from any state to the highest-priority enabled source that is pending. The transitions follow this order: line status first, then data available, then timeout, then holding-register-empty, then modem. When no enabled source is pending it moves to `SRC_NONE`.

Top module: `uart_irq_ident`

## Requirements
- R1: Enable bit 0 gates both data available and timeout, bit 1 gates holding-register-empty, bit 2 gates line status and bit 3 gates modem status. A gated-off source neither appears in the identification byte nor raises `irq`. A latched holding-register-empty event is kept while it is gated off and shows once its enable bit is set.
- R2: An enabled line-status error is reported with identification code 3'b011 ahead of every other source.
- R3: Data available (code 3'b010) and character timeout (code 3'b110) share the second priority level. When both are pending, data available is reported.
- R4: In FIFO mode, data available holds while `rx_count` is at or above the trigger level chosen by `rx_trig_sel`: 2'b00 means 1, 2'b01 means 4, 2'b10 means 8 and 2'b11 means 14. In non-FIFO mode it holds while `rx_count` is non-zero, and the trigger select has no effect.
- R5: Holding-register-empty is reported with code 3'b001 at the third level. Modem status is reported with code 3'b000 at the fourth level.
- R6: The identification byte is laid out as follows. Bits [7:6] read 2'b11 while FIFO mode is on and 2'b00 otherwise. Bits [5:4] read 2'b00. Bits [3:1] hold the code of the reported source. Bit 0 is 0 while an interrupt is pending and 1 otherwise. With nothing pending, bits [3:0] read 4'b0001.
- R7: During and after reset the identification byte reads 8'h01, `irq` is 0 and the holding-register-empty latch is clear.
- R8: A pulse on `thr_wr` clears the holding-register-empty latch. A new event arriving in the same cycle wins, and the latch stays set.
- R9: A pulse on `iir_rd` clears the holding-register-empty latch only while that source is the one reported. A read while another source is reported leaves the latch set.
- R10: The identification byte and `irq` reflect level sources one clock edge after they change. A holding-register-empty event, or a clear of it, is reflected two edges after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_en | input | 4 | Interrupt enable bits |
| fifo_mode | input | 1 | FIFO mode enabled |
| rx_trig_sel | input | 2 | Receive trigger level select |
| rx_count | input | CNT_W | Receive FIFO fill count (or unread-data count) |
| rx_line_err | input | 1 | Receiver line-status error pending |
| rx_timeout | input | 1 | Character timeout pending |
| thr_empty_evt | input | 1 | Pulse: holding register became empty |
| modem_req | input | 1 | Modem-status change pending |
| iir_rd | input | 1 | Pulse: identification byte is being read |
| thr_wr | input | 1 | Pulse: transmit register is being written |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Registered active-high interrupt level |

## Verification
A change on a level source or on `fifo_mode` is due in `iir` and `irq` one rising edge later. A holding-register-empty event, or a read or write that clears it, passes through the latch and then the state register, so its effect is due two edges after the pulse. The bench drives every input on the falling edge. It then waits exactly one or two rising edges, as the requirement under test sets, and samples at the next falling edge. Where a pulse is involved, it also samples at the intermediate edge to confirm that nothing has changed too early.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_LINE,
        SRC_DATA,
        SRC_TOUT,
        SRC_TXE,
        SRC_MODEM
    } irq_src_e;

    localparam logic [2:0] CODE_LINE  = 3'b011;
    localparam logic [2:0] CODE_DATA  = 3'b010;
    localparam logic [2:0] CODE_TOUT  = 3'b110;
    localparam logic [2:0] CODE_TXE   = 3'b001;
    localparam logic [2:0] CODE_MODEM = 3'b000;

    localparam int EN_RX    = 0;
    localparam int EN_TXE   = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

endpackage

// File: rtl/uart_irq_rda.sv
`timescale 1ns/1ps
module uart_irq_rda #(
    parameter int CNT_W = 5,
    parameter int LVL0  = 1,
    parameter int LVL1  = 4,
    parameter int LVL2  = 8,
    parameter int LVL3  = 14
) (
    input  logic             fifo_mode,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] count,
    output logic             rda
);
    logic [CNT_W-1:0] level;

    always_comb begin
        unique case (trig_sel)
            2'b00:   level = CNT_W'(LVL0);
            2'b01:   level = CNT_W'(LVL1);
            2'b10:   level = CNT_W'(LVL2);
            default: level = CNT_W'(LVL3);
        endcase
    end

    assign rda = fifo_mode ? (count >= level) : (count != '0);
endmodule

// File: rtl/uart_irq_txe.sv
`timescale 1ns/1ps
module uart_irq_txe (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic wr_clr,
    input  logic rd_clr,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (set_evt)
            flag <= 1'b1;
        else if (wr_clr || rd_clr)
            flag <= 1'b0;
    end
endmodule

// File: rtl/uart_irq_fsm.sv
`timescale 1ns/1ps
module uart_irq_fsm
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] en,
    input  logic       fifo_mode,
    input  logic       line_p,
    input  logic       data_p,
    input  logic       tout_p,
    input  logic       txe_p,
    input  logic       modem_p,
    output logic [7:0] iir,
    output logic       irq,
    output logic       txe_shown
);
    irq_src_e state, nxt;
    logic     fifo_q;
    logic     irq_q;

    always_comb begin
        if (en[EN_LINE] && line_p)        nxt = SRC_LINE;
        else if (en[EN_RX] && data_p)     nxt = SRC_DATA;
        else if (en[EN_RX] && tout_p)     nxt = SRC_TOUT;
        else if (en[EN_TXE] && txe_p)     nxt = SRC_TXE;
        else if (en[EN_MODEM] && modem_p) nxt = SRC_MODEM;
        else                              nxt = SRC_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= SRC_NONE;
            fifo_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            state  <= nxt;
            fifo_q <= fifo_mode;
            irq_q  <= (nxt != SRC_NONE);
        end
    end

    always_comb begin
        logic [2:0] code;
        unique case (state)
            SRC_LINE:  code = CODE_LINE;
            SRC_DATA:  code = CODE_DATA;
            SRC_TOUT:  code = CODE_TOUT;
            SRC_TXE:   code = CODE_TXE;
            SRC_MODEM: code = CODE_MODEM;
            default:   code = 3'b000;
        endcase
        iir       = {{2{fifo_q}}, 2'b00, code, ~irq_q};
        irq       = irq_q;
        txe_shown = (state == SRC_TXE);
    end
endmodule

// File: rtl/uart_irq_ident.sv
`timescale 1ns/1ps
module uart_irq_ident #(
    parameter int CNT_W = 5,
    parameter int LVL0  = 1,
    parameter int LVL1  = 4,
    parameter int LVL2  = 8,
    parameter int LVL3  = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       irq_en,
    input  logic             fifo_mode,
    input  logic [1:0]       rx_trig_sel,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_line_err,
    input  logic             rx_timeout,
    input  logic             thr_empty_evt,
    input  logic             modem_req,
    input  logic             iir_rd,
    input  logic             thr_wr,
    output logic [7:0]       iir,
    output logic             irq
);
    logic rda;
    logic txe_flag;
    logic txe_shown;

    uart_irq_rda #(
        .CNT_W(CNT_W), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
    ) u_rda (
        .fifo_mode (fifo_mode),
        .trig_sel  (rx_trig_sel),
        .count     (rx_count),
        .rda       (rda)
    );

    uart_irq_txe u_txe (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (thr_empty_evt),
        .wr_clr  (thr_wr),
        .rd_clr  (iir_rd && txe_shown),
        .flag    (txe_flag)
    );

    uart_irq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (irq_en),
        .fifo_mode (fifo_mode),
        .line_p    (rx_line_err),
        .data_p    (rda),
        .tout_p    (rx_timeout),
        .txe_p     (txe_flag),
        .modem_p   (modem_req),
        .iir       (iir),
        .irq       (irq),
        .txe_shown (txe_shown)
    );
endmodule

// File: rtl/uart_irq_ident_chk.sv
`timescale 1ns/1ps
module uart_irq_ident_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       irq_en,
    input logic             fifo_mode,
    input logic [CNT_W-1:0] rx_count,
    input logic             rx_line_err,
    input logic             rx_timeout,
    input logic             thr_empty_evt,
    input logic             thr_wr,
    input logic [7:0]       iir,
    input logic             irq
);
    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 4'b0000) |=> !irq);  // R1

    AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en[2] && rx_line_err) |=> (iir[3:0] == 4'b0110));  // R2

    AST_DATA_OVER_TOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!(irq_en[2] && rx_line_err) && irq_en[0] && rx_timeout && fifo_mode
         && (rx_count >= CNT_W'(14))) |=> (iir[3:0] == 4'b0100));  // R3

    AST_FIFO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (iir[7:4] == {{2{$past(fifo_mode)}}, 2'b00}));  // R6

    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (iir[3:0] == 4'b0001));  // R6

    AST_TXE_WR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && !thr_empty_evt) |-> ##2 !(irq && iir[3:1] == 3'b001));  // R8
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_en        (irq_en),
    .fifo_mode     (fifo_mode),
    .rx_count      (rx_count),
    .rx_line_err   (rx_line_err),
    .rx_timeout    (rx_timeout),
    .thr_empty_evt (thr_empty_evt),
    .thr_wr        (thr_wr),
    .iir           (iir),
    .irq           (irq)
);

// File: tb/uart_irq_ident_bench.sv
`timescale 1ns/1ps
module uart_irq_ident_bench;
    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       irq_en = '0;
    logic             fifo_mode = 1'b0;
    logic [1:0]       rx_trig_sel = '0;
    logic [CNT_W-1:0] rx_count = '0;
    logic             rx_line_err = 1'b0;
    logic             rx_timeout = 1'b0;
    logic             thr_empty_evt = 1'b0;
    logic             modem_req = 1'b0;
    logic             iir_rd = 1'b0;
    logic             thr_wr = 1'b0;
    logic [7:0]       iir;
    logic             irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    uart_irq_ident #(.CNT_W(CNT_W)) u_uart_irq_ident (
        .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .fifo_mode(fifo_mode),
        .rx_trig_sel(rx_trig_sel), .rx_count(rx_count), .rx_line_err(rx_line_err),
        .rx_timeout(rx_timeout), .thr_empty_evt(thr_empty_evt), .modem_req(modem_req),
        .iir_rd(iir_rd), .thr_wr(thr_wr), .iir(iir), .irq(irq)
    );

    // Row layout: en[4] fifo[1] trig[2] cnt[5] err tout modem exp_iir[8] exp_irq
    localparam int NV = 16;
    localparam logic [24:0] VEC [NV] = '{
        {4'b0000, 1'b0, 2'b00, 5'd5,  1'b1, 1'b1, 1'b1, 8'h01, 1'b0},  // R1
        {4'b0100, 1'b0, 2'b00, 5'd0,  1'b1, 1'b0, 1'b0, 8'h06, 1'b1},  // R2
        {4'b1111, 1'b1, 2'b01, 5'd5,  1'b1, 1'b1, 1'b1, 8'hC6, 1'b1},  // R2 R6
        {4'b0001, 1'b1, 2'b01, 5'd4,  1'b0, 1'b0, 1'b0, 8'hC4, 1'b1},  // R4
        {4'b0001, 1'b1, 2'b01, 5'd3,  1'b0, 1'b0, 1'b0, 8'hC1, 1'b0},  // R4
        {4'b0001, 1'b1, 2'b11, 5'd13, 1'b0, 1'b0, 1'b0, 8'hC1, 1'b0},  // R4
        {4'b0001, 1'b1, 2'b11, 5'd14, 1'b0, 1'b0, 1'b0, 8'hC4, 1'b1},  // R4
        {4'b0001, 1'b1, 2'b10, 5'd8,  1'b0, 1'b0, 1'b0, 8'hC4, 1'b1},  // R4
        {4'b0001, 1'b1, 2'b00, 5'd1,  1'b0, 1'b0, 1'b0, 8'hC4, 1'b1},  // R4
        {4'b0001, 1'b1, 2'b00, 5'd0,  1'b0, 1'b0, 1'b0, 8'hC1, 1'b0},  // R4
        {4'b0001, 1'b0, 2'b11, 5'd1,  1'b0, 1'b0, 1'b0, 8'h04, 1'b1},  // R4 non-FIFO
        {4'b0001, 1'b1, 2'b11, 5'd0,  1'b0, 1'b1, 1'b0, 8'hCC, 1'b1},  // R3
        {4'b0001, 1'b1, 2'b11, 5'd14, 1'b0, 1'b1, 1'b0, 8'hC4, 1'b1},  // R3
        {4'b1000, 1'b0, 2'b00, 5'd0,  1'b0, 1'b0, 1'b1, 8'h00, 1'b1},  // R5
        {4'b1001, 1'b0, 2'b00, 5'd1,  1'b0, 1'b0, 1'b1, 8'h04, 1'b1},  // R3
        {4'b0111, 1'b0, 2'b00, 5'd0,  1'b0, 1'b0, 1'b1, 8'h01, 1'b0}   // R1
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic [7:0] e_iir, input logic e_irq, input string req);
        total++;
        if (iir !== e_iir || irq !== e_irq) begin
            bad++;
            $display("FAIL %s iir=%02h irq=%0b expected iir=%02h irq=%0b",
                     req, iir, irq, e_iir, e_irq);
        end
    endtask

    task automatic quiet();
        irq_en = '0; fifo_mode = 0; rx_trig_sel = '0; rx_count = '0;
        rx_line_err = 0; rx_timeout = 0; modem_req = 0;
        thr_empty_evt = 0; iir_rd = 0; thr_wr = 0;
    endtask

    initial begin
        repeat (1000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        chk(8'h01, 1'b0, "R7 during reset");
        step(2);
        rst_n = 1'b1;
        step(1);
        chk(8'h01, 1'b0, "R7 after reset");

        for (int i = 0; i < NV; i++) begin
            {irq_en, fifo_mode, rx_trig_sel, rx_count, rx_line_err,
             rx_timeout, modem_req} = VEC[i][24:9];
            step(1);
            chk(VEC[i][8:1], VEC[i][0], $sformatf("vector %0d (R1..R6 table)", i));
        end

        // R5 R10: holding-register-empty event, two edges to appear
        quiet();
        irq_en = 4'b0010;
        thr_empty_evt = 1;
        step(1);
        thr_empty_evt = 0;
        chk(8'h01, 1'b0, "R10 txe not yet");
        step(1);
        chk(8'h02, 1'b1, "R5 txe reported");

        // R9: read while reported clears
        iir_rd = 1;
        step(1);
        iir_rd = 0;
        chk(8'h02, 1'b1, "R10 txe read lag");
        step(1);
        chk(8'h01, 1'b0, "R9 read clears txe");

        // R8: transmit write clears
        thr_empty_evt = 1;
        step(1);
        thr_empty_evt = 0;
        step(1);
        thr_wr = 1;
        step(1);
        thr_wr = 0;
        step(1);
        chk(8'h01, 1'b0, "R8 write clears txe");

        // R8: event wins over same-cycle write
        thr_empty_evt = 1;
        thr_wr = 1;
        step(1);
        thr_empty_evt = 0;
        thr_wr = 0;
        step(1);
        chk(8'h02, 1'b1, "R8 set wins");

        // R9: read while line status reported keeps txe
        irq_en = 4'b0110;
        rx_line_err = 1;
        step(1);
        chk(8'h06, 1'b1, "R2 line over txe");
        iir_rd = 1;
        step(1);
        iir_rd = 0;
        rx_line_err = 0;
        step(1);
        chk(8'h02, 1'b1, "R9 other read keeps txe");
        thr_wr = 1;
        step(1);
        thr_wr = 0;
        step(1);
        chk(8'h01, 1'b0, "R8 cleanup");

        // R1: masked txe event is held and shows when enabled
        irq_en = 4'b0000;
        thr_empty_evt = 1;
        step(1);
        thr_empty_evt = 0;
        step(2);
        chk(8'h01, 1'b0, "R1 masked txe hidden");
        irq_en = 4'b0010;
        step(1);
        chk(8'h02, 1'b1, "R1 txe shows on enable");

        // R7: reset clears the latched event
        rst_n = 0;
        step(1);
        chk(8'h01, 1'b0, "R7 reset mid-run");
        rst_n = 1;
        step(2);
        chk(8'h01, 1'b0, "R7 latch cleared by reset");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule